// File: doc/BRIEF.md
# Row-Selectable Latin-Square Parity Encoder

This block produces the parity bits of a one-step majority-decodable code for a memory word laid out as an M×M grid of data bits. The full code has 2·T·M parity bits and corrects T random errors. The parity bits fall into 2·T groups of M: one group over the grid rows, one over the grid columns, and the rest over the symbols of mutually orthogonal Latin squares. Because the squares are orthogonal, two data bits never meet in more than one parity equation.

A mask register, loaded through a one-cycle strobe, keeps or drops each parity equation individually. A compaction network gathers the kept parity bits into a narrow field starting at bit 0, so the memory only has to store as many parity bits as the mask keeps. The field comes out registered, together with the number of meaningful bits in it. The mask is normally chosen after a defect map of the array is known.

With the defaults (M=5, T=2) the word has 25 data bits and the full code has 20 parity bits.

Top module: `ols_sel_encoder`

## Requirements
- R1: After reset, `out_valid` is 0, `out_chk` is all zeros, `out_count` is 0, and the mask register holds all ones, so every parity bit is kept.
- R2: Parity bit i = g·M + k (group g, slot k) is the XOR of every data bit (r,c), where data bit index = r·M + c, that meets the group's condition: for g=0, r = k; for g=1, c = k; for g≥2, ((g−1)·r + c) mod M = k.
- R3: A word with a single data bit set gives exactly 2·T set bits in the full parity vector, one in each group.
- R4: A word with exactly two data bits set gives at least 4·T−2 set bits in the full parity vector, because the two bits share at most one equation.
- R5: The kept parity bits appear in `out_chk` in ascending full-vector index order, and the lowest kept bit goes to packed bit 0.
- R6: Every bit of `out_chk` at position `out_count` or above is 0.
- R7: `out_count` equals the number of ones in the mask that was used for the word.
- R8: A word presented with `in_valid` high at a clock edge comes out one cycle later with `out_valid` high. `out_valid` is low after any edge that sees `in_valid` low, and in that case `out_chk` and `out_count` keep their values.
- R9: `cfg_load` high at an edge copies `cfg_en` into the mask register. While `cfg_load` is low, `cfg_en` has no effect.
- R10: Encoding is never stalled. A word taken at the same edge as a mask load is encoded with the previous mask, and later words use the new mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Strobe that writes the mask register |
| cfg_en | input | 2·T·M | New mask; bit i keeps parity bit i |
| in_valid | input | 1 | A data word is present |
| in_data | input | M·M | Data word, bit r·M+c is grid cell (r,c) |
| out_valid | output | 1 | Packed field is valid |
| out_chk | output | 2·T·M | Packed kept parity bits, zero above the count |
| out_count | output | clog2(2·T·M+1) | Number of kept parity bits |

## Verification
The encoder is tried with the following inputs:
- Every single-bit word. This separates the four parity groups from each other and catches a wrong slot formula in any group.
- Adjacent and diagonal bit pairs. These test the one-shared-equation property, which only holds if the squares are truly orthogonal.
- Dense and random-looking words under the full mask, the empty mask, alternating masks and one-bit masks. These test the compaction order and the zero fill above the count.
- A mask load in the same cycle as a word, a mask value changed without a strobe, and idle cycles with changing data. These separate the old mask from the new mask and check that the outputs hold.

// File: rtl/ols_enc_pkg.sv
package ols_enc_pkg;

  // True when grid cell (r,c) belongs to equation k of group grp.
  function automatic bit cell_in_eq(int m, int grp, int k, int r, int c);
    if (grp == 0)      return (r == k);
    else if (grp == 1) return (c == k);
    else               return ((((grp - 1) * r) + c) % m) == k;
  endfunction

endpackage

// File: rtl/ols_parity_gen.sv
module ols_parity_gen #(
  parameter int M = 5,
  parameter int T = 2
) (
  input  logic [M*M-1:0]   data,
  output logic [2*T*M-1:0] full_chk
);
  import ols_enc_pkg::*;

  localparam int NCHK = 2 * T * M;

  for (genvar gi = 0; gi < NCHK; gi++) begin : g_eq
    localparam int GRP  = gi / M;
    localparam int SLOT = gi % M;
    always_comb begin
      full_chk[gi] = 1'b0;
      for (int r = 0; r < M; r++) begin
        for (int c = 0; c < M; c++) begin
          if (cell_in_eq(M, GRP, SLOT, r, c))
            full_chk[gi] = full_chk[gi] ^ data[r*M + c];
        end
      end
    end
  end

endmodule

// File: rtl/ols_pack.sv
module ols_pack #(
  parameter int N  = 20,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  full_chk,
  input  logic [N-1:0]  keep,
  output logic [N-1:0]  packed_chk,
  output logic [CW-1:0] kept_cnt
);
  always_comb begin
    packed_chk = '0;
    kept_cnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (keep[i]) begin
        packed_chk[kept_cnt] = full_chk[i];
        kept_cnt = kept_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ols_mask_reg.sv
module ols_mask_reg #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] din,
  output logic [N-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)       mask <= '1;
    else if (load) mask <= din;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> (mask == $past(din))); // R9
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable(mask)); // R9
endmodule

// File: rtl/ols_sel_encoder.sv
module ols_sel_encoder #(
  parameter int M = 5,
  parameter int T = 2,
  localparam int NDATA = M * M,
  localparam int NCHK  = 2 * T * M,
  localparam int CW    = $clog2(NCHK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [NCHK-1:0]  cfg_en,
  input  logic             in_valid,
  input  logic [NDATA-1:0] in_data,
  output logic             out_valid,
  output logic [NCHK-1:0]  out_chk,
  output logic [CW-1:0]    out_count
);
  logic [NCHK-1:0] mask_q;
  logic [NCHK-1:0] full_chk;
  logic [NCHK-1:0] packed_chk;
  logic [CW-1:0]   kept_cnt;

  ols_mask_reg #(.N(NCHK)) u_mask (
    .clk (clk), .rst (rst), .load (cfg_load), .din (cfg_en), .mask (mask_q)
  );

  ols_parity_gen #(.M(M), .T(T)) u_par (
    .data (in_data), .full_chk (full_chk)
  );

  AST_ONE_PER_GROUP: assert property (@(posedge clk) disable iff (rst)
    ($countones(in_data) == 1) |-> ($countones(full_chk) == 2 * T)); // R3
  AST_PAIR_SHARES_ONE: assert property (@(posedge clk) disable iff (rst)
    ($countones(in_data) == 2) |-> ($countones(full_chk) >= 4 * T - 2)); // R4

  ols_pack #(.N(NCHK), .CW(CW)) u_pack (
    .full_chk (full_chk), .keep (mask_q),
    .packed_chk (packed_chk), .kept_cnt (kept_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chk   <= '0;
      out_count <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chk   <= packed_chk;
        out_count <= kept_cnt;
      end
    end
  end

  AST_ZERO_ABOVE_COUNT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_chk >> out_count) == '0)); // R6
  AST_COUNT_IS_MASK_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> (int'(out_count) == $countones($past(mask_q)))); // R7
  AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(out_chk) && $stable(out_count))); // R8
endmodule

// File: tb/sim_ols_sel_encoder.sv
module sim_ols_sel_encoder;
  localparam int M = 5;
  localparam int T = 2;
  localparam int ND = M * M;
  localparam int NC = 2 * T * M;
  localparam int CW = $clog2(NC + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0;
  logic [NC-1:0] cfg_en = '0;
  logic in_valid = 1'b0;
  logic [ND-1:0] in_data = '0;
  logic out_valid;
  logic [NC-1:0] out_chk;
  logic [CW-1:0] out_count;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ols_sel_encoder #(.M(M), .T(T)) u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_en(cfg_en),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_chk(out_chk), .out_count(out_count)
  );

  function automatic logic [NC-1:0] ref_full(logic [ND-1:0] d);
    logic [NC-1:0] p = '0;
    for (int r = 0; r < M; r++)
      for (int c = 0; c < M; c++)
        if (d[r*M + c]) begin
          p[r] = ~p[r];
          p[M + c] = ~p[M + c];
          for (int s = 1; s <= 2*T - 2; s++)
            p[(s+1)*M + ((s*r + c) % M)] = ~p[(s+1)*M + ((s*r + c) % M)];
        end
    return p;
  endfunction

  function automatic logic [NC-1:0] ref_pack(logic [NC-1:0] f, logic [NC-1:0] en);
    logic [NC-1:0] q = '0;
    int j = 0;
    for (int i = 0; i < NC; i++)
      if (en[i]) begin q[j] = f[i]; j++; end
    return q;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one word, then compare the registered result one cycle later.
  task automatic encode(logic [ND-1:0] d, logic [NC-1:0] en, string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, req, {31'd0, out_valid}, 32'd1);
    check(out_chk === ref_pack(ref_full(d), en), req, {12'd0, out_chk}, {12'd0, ref_pack(ref_full(d), en)});
    check(int'(out_count) == $countones(en), req, {27'd0, out_count}, $countones(en));
  endtask

  task automatic load_mask(logic [NC-1:0] en);
    @(negedge clk);
    cfg_load = 1'b1; cfg_en = en;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0, "R1 valid", {31'd0, out_valid}, 0);
    check(out_chk === '0, "R1 chk", {12'd0, out_chk}, 0);
    check(out_count === '0, "R1 count", {27'd0, out_count}, 0);
    encode({ND{1'b1}}, {NC{1'b1}}, "R1 mask all ones");
  endtask

  task automatic t_single_bits();
    for (int b = 0; b < ND; b++) begin
      encode(ND'(1) << b, {NC{1'b1}}, "R2 R3 single bit");
      check($countones(out_chk) == 2*T, "R3 weight", $countones(out_chk), 2*T);
    end
  endtask

  task automatic t_pairs();
    encode(25'h3, {NC{1'b1}}, "R4 adjacent pair");
    check($countones(out_chk) >= 4*T-2, "R4 adjacent", $countones(out_chk), 4*T-2);
    encode((25'd1 << 0) | (25'd1 << 6), {NC{1'b1}}, "R4 diagonal pair");
    check($countones(out_chk) >= 4*T-2, "R4 diagonal", $countones(out_chk), 4*T-2);
    encode((25'd1 << 3) | (25'd1 << 21), {NC{1'b1}}, "R4 far pair");
    check($countones(out_chk) >= 4*T-2, "R4 far", $countones(out_chk), 4*T-2);
  endtask

  task automatic t_masks();
    logic [NC-1:0] m;
    m = 20'hAAAAA; load_mask(m);
    encode(25'h1A2B3C4, m, "R5 R6 alternating mask");
    m = 20'h80000; load_mask(m);
    encode(25'h1FFFFFF, m, "R5 top bit only");
    m = 20'h00000; load_mask(m);
    encode(25'h1555555, m, "R6 R7 empty mask");
    m = 20'hF0F03; load_mask(m);
    encode(25'h0ABCDEF, m, "R5 R7 mixed mask");
    encode(25'h1234567, m, "R2 R5 mixed mask data2");
  endtask

  task automatic t_ignored();
    @(negedge clk);
    cfg_en = 20'h00001;
    encode(25'h0F0F0F0, 20'hF0F03, "R9 unstrobed cfg_en ignored");
  endtask

  task automatic t_concurrent();
    logic [NC-1:0] old_m = 20'hF0F03;
    logic [NC-1:0] new_m = 20'h0FFF0;
    @(negedge clk);
    cfg_load = 1'b1; cfg_en = new_m;
    in_valid = 1'b1; in_data = 25'h1C3A5F1;
    @(negedge clk);
    cfg_load = 1'b0; in_valid = 1'b0;
    check(out_valid === 1'b1, "R10 not stalled", {31'd0, out_valid}, 1);
    check(out_chk === ref_pack(ref_full(25'h1C3A5F1), old_m), "R10 old mask used",
          {12'd0, out_chk}, {12'd0, ref_pack(ref_full(25'h1C3A5F1), old_m)});
    encode(25'h1C3A5F1, new_m, "R9 R10 new mask next word");
  endtask

  task automatic t_hold();
    logic [NC-1:0] held;
    encode(25'h0777777, 20'h0FFF0, "R8 before idle");
    held = out_chk;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_data = 25'h1000000 >> i;
      check(out_valid === 1'b0, "R8 idle valid low", {31'd0, out_valid}, 0);
      check(out_chk === held, "R8 idle hold", {12'd0, out_chk}, {12'd0, held});
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single_bits();
    t_pairs();
    t_masks();
    t_ignored();
    t_concurrent();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule